// File: doc/BRIEF.md
# Fine-Grained Warp Issue Scheduler

This block picks one warp per clock from a pool of resident warps and presents that warp's next instruction address to a shared SIMD pipeline. Because every warp's register values stay resident, moving from one warp to another costs nothing. The pipeline can therefore interleave different warps on consecutive cycles and hide pipeline and memory latency.

Each warp is in one of three states: ready, busy or parked. A busy warp has its single instruction in the pipeline. There is no branch prediction, so the warp stays out of scheduling until a writeback report supplies its next PC. A load-result report from the modelled data-cache stage either leaves the warp busy, when every thread hit, or parks it, when any thread missed. A parked warp waits for a memory-return event, which completes its load and makes it ready again. Among ready warps, the pick is round-robin, starting just after the warp issued most recently.

Top module: `warp_issue_sched`

## Requirements
- R1: While the synchronous reset is high, every warp is set ready at PC 0 with nothing in flight and the round-robin pointer is set to the highest warp id. The first issue after reset is therefore warp 0 at PC 0.
- R2: On a cycle with `issue_valid` high, the warp shown on `issue_wid` becomes busy at the next edge. It is not shown again until a writeback or a memory return resolves it.
- R3: Among the ready warps, the one chosen is the first found counting upward from the last issued warp id plus one, wrapping from the highest id to 0.
- R4: `issue_valid` is low in exactly those cycles in which no warp is ready.
- R5: A writeback with `wb_is_branch` low sets that warp's PC to its old PC plus 4 and makes the warp eligible on the next cycle.
- R6: A writeback with `wb_is_branch` high loads `wb_target` as that warp's PC and makes the warp eligible on the next cycle.
- R7: A load-result report with `mem_all_hit` high leaves the warp busy. The warp is issued again only after its writeback.
- R8: A load-result report with `mem_all_hit` low parks the warp. A parked warp is never issued.
- R9: A memory return for a parked warp advances its PC by 4 and makes it eligible on the next cycle.
- R10: Different warps are issued on consecutive cycles with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_valid | input | 1 | Writeback report for one busy warp |
| wb_wid | input | 3 | Warp id of the writeback |
| wb_is_branch | input | 1 | Completed instruction was a branch |
| wb_target | input | 32 | Branch target PC |
| mem_result_valid | input | 1 | Load-result report from the cache stage |
| mem_result_wid | input | 3 | Warp id of the load result |
| mem_all_hit | input | 1 | 1 when every thread hit, 0 when any thread missed |
| mem_return_valid | input | 1 | Memory return that wakes a parked warp |
| mem_return_wid | input | 3 | Warp id of the memory return |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_wid | output | 3 | Warp id issued |
| issue_pc | output | 32 | PC of the issued instruction |

## Verification
The assertions take for granted that the environment is consistent. A writeback or load result names only a busy warp, a memory return names only a parked warp, and a single warp never receives a writeback and a load result in the same cycle. The bench follows these rules by tracking which warps it has seen issued, parked or woken. It reports an event for a warp only after the cycle in which that warp entered the state the event requires.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int WS_PC_W    = 32;
  localparam int WS_PC_STEP = 4;

  typedef enum logic [1:0] {
    WS_READY  = 2'd0,
    WS_BUSY   = 2'd1,
    WS_PARKED = 2'd2
  } wstate_e;

  // sequential successor of a PC
  function automatic logic [WS_PC_W-1:0] ws_seq_pc(input logic [WS_PC_W-1:0] pc);
    return pc + WS_PC_W'(WS_PC_STEP);
  endfunction

  // PC after an instruction resolves at writeback
  function automatic logic [WS_PC_W-1:0] ws_wb_pc(input logic [WS_PC_W-1:0] pc,
                                                  input logic is_br,
                                                  input logic [WS_PC_W-1:0] tgt);
    return is_br ? tgt : ws_seq_pc(pc);
  endfunction
endpackage

// File: rtl/wsched_warp_slot.sv
module wsched_warp_slot
  import wsched_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_hit,
  input  logic               wb_hit,
  input  logic               wb_is_branch,
  input  logic [WS_PC_W-1:0] wb_target,
  input  logic               park_hit,
  input  logic               wake_hit,
  output logic               ready,
  output logic               parked,
  output logic [WS_PC_W-1:0] pc
);
  wstate_e st_q;
  logic [WS_PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= WS_READY;
      pc_q <= '0;
    end else begin
      unique case (st_q)
        WS_READY: if (issue_hit) st_q <= WS_BUSY;
        WS_BUSY: begin
          if (park_hit) begin
            st_q <= WS_PARKED;
          end else if (wb_hit) begin
            pc_q <= ws_wb_pc(pc_q, wb_is_branch, wb_target);
            st_q <= WS_READY;
          end
        end
        WS_PARKED: if (wake_hit) begin
          pc_q <= ws_seq_pc(pc_q);
          st_q <= WS_READY;
        end
        default: st_q <= WS_READY;
      endcase
    end
  end

  assign ready  = (st_q == WS_READY);
  assign parked = (st_q == WS_PARKED);
  assign pc     = pc_q;
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic [NUM_WARPS-1:0] ready_vec,
  input  logic [WID_W-1:0]     last_wid,
  output logic                 pick_valid,
  output logic [WID_W-1:0]     pick_wid
);
  // search upward from last+1, wrapping; returns {found, id}
  function automatic logic [WID_W:0] rr_search(input logic [NUM_WARPS-1:0] rdy,
                                               input logic [WID_W-1:0] last);
    logic [WID_W:0] res;
    res = '0;
    for (int off = NUM_WARPS; off >= 1; off--) begin
      int idx;
      idx = (int'(last) + off) % NUM_WARPS;
      if (rdy[idx]) res = {1'b1, WID_W'(idx)};
    end
    return res;
  endfunction

  logic [WID_W:0] found;
  assign found      = rr_search(ready_vec, last_wid);
  assign pick_valid = found[WID_W];
  assign pick_wid   = found[WID_W-1:0];
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wb_valid,
  input  logic [WID_W-1:0]   wb_wid,
  input  logic               wb_is_branch,
  input  logic [WS_PC_W-1:0] wb_target,
  input  logic               mem_result_valid,
  input  logic [WID_W-1:0]   mem_result_wid,
  input  logic               mem_all_hit,
  input  logic               mem_return_valid,
  input  logic [WID_W-1:0]   mem_return_wid,
  output logic               issue_valid,
  output logic [WID_W-1:0]   issue_wid,
  output logic [WS_PC_W-1:0] issue_pc
);
  // named per-warp events
  logic [NUM_WARPS-1:0] issue_ev, wb_ev, park_ev, wake_ev;
  logic [NUM_WARPS-1:0] ready_vec, parked_vec;
  logic [NUM_WARPS-1:0][WS_PC_W-1:0] pc_vec;
  logic [WID_W-1:0] last_q;
  logic             pick_valid;
  logic [WID_W-1:0] pick_wid;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
    assign issue_ev[g] = pick_valid && (pick_wid == WID_W'(g));
    assign wb_ev[g]    = wb_valid && (wb_wid == WID_W'(g));
    assign park_ev[g]  = mem_result_valid && !mem_all_hit && (mem_result_wid == WID_W'(g));
    assign wake_ev[g]  = mem_return_valid && (mem_return_wid == WID_W'(g));

    wsched_warp_slot u_slot (
      .clk          (clk),
      .rst          (rst),
      .issue_hit    (issue_ev[g]),
      .wb_hit       (wb_ev[g]),
      .wb_is_branch (wb_is_branch),
      .wb_target    (wb_target),
      .park_hit     (park_ev[g]),
      .wake_hit     (wake_ev[g]),
      .ready        (ready_vec[g]),
      .parked       (parked_vec[g]),
      .pc           (pc_vec[g])
    );
  end

  wsched_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .ready_vec  (ready_vec),
    .last_wid   (last_q),
    .pick_valid (pick_valid),
    .pick_wid   (pick_wid)
  );

  always_ff @(posedge clk) begin
    if (rst)             last_q <= WID_W'(NUM_WARPS - 1);
    else if (pick_valid) last_q <= pick_wid;
  end

  assign issue_valid = pick_valid;
  assign issue_wid   = pick_wid;
  assign issue_pc    = pc_vec[pick_wid];
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              issue_valid,
  input logic [WID_W-1:0]                  issue_wid,
  input logic [NUM_WARPS-1:0]              ready_vec,
  input logic [NUM_WARPS-1:0]              parked_vec,
  input logic [NUM_WARPS-1:0][31:0]        pc_vec,
  input logic                              wb_valid,
  input logic [WID_W-1:0]                  wb_wid,
  input logic                              wb_is_branch,
  input logic [31:0]                       wb_target,
  input logic                              mem_result_valid,
  input logic [WID_W-1:0]                  mem_result_wid,
  input logic                              mem_all_hit,
  input logic                              mem_return_valid,
  input logic [WID_W-1:0]                  mem_return_wid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (&ready_vec) && (parked_vec == '0));
  // R2
  no_reissue_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> !(issue_valid && issue_wid == $past(issue_wid)));
  // R4
  idle_only_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_vec != '0) |-> issue_valid);
  // R4
  issue_is_ready_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> ready_vec[issue_wid]);
  // R5
  wb_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_is_branch && !(mem_result_valid && mem_result_wid == wb_wid)) |=>
      (pc_vec[$past(wb_wid)] == $past(pc_vec[wb_wid]) + 32'd4) && ready_vec[$past(wb_wid)]);
  // R6
  wb_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_is_branch && !(mem_result_valid && mem_result_wid == wb_wid)) |=>
      (pc_vec[$past(wb_wid)] == $past(wb_target)));
  // R8
  park_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_result_valid && !mem_all_hit) |=> parked_vec[$past(mem_result_wid)]);
  // R8
  parked_never_issued_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !parked_vec[issue_wid]);
  // R9
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    mem_return_valid |=> ready_vec[$past(mem_return_wid)]);
endmodule

bind warp_issue_sched wsched_chk #(.NUM_WARPS(NUM_WARPS)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .issue_valid      (issue_valid),
  .issue_wid        (issue_wid),
  .ready_vec        (ready_vec),
  .parked_vec       (parked_vec),
  .pc_vec           (pc_vec),
  .wb_valid         (wb_valid),
  .wb_wid           (wb_wid),
  .wb_is_branch     (wb_is_branch),
  .wb_target        (wb_target),
  .mem_result_valid (mem_result_valid),
  .mem_result_wid   (mem_result_wid),
  .mem_all_hit      (mem_all_hit),
  .mem_return_valid (mem_return_valid),
  .mem_return_wid   (mem_return_wid)
);

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_valid = 1'b0;
  logic [2:0]  wb_wid = '0;
  logic        wb_is_branch = 1'b0;
  logic [31:0] wb_target = '0;
  logic        mem_result_valid = 1'b0;
  logic [2:0]  mem_result_wid = '0;
  logic        mem_all_hit = 1'b0;
  logic        mem_return_valid = 1'b0;
  logic [2:0]  mem_return_wid = '0;
  logic        issue_valid;
  logic [2:0]  issue_wid;
  logic [31:0] issue_pc;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  warp_issue_sched u0 (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wb_valid = 1'b0; mem_result_valid = 1'b0; mem_return_valid = 1'b0;
    wb_is_branch = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_issue(input string req, input logic [2:0] wid, input logic [31:0] pc);
    chk({req, " valid"}, 32'(issue_valid), 32'd1);
    chk({req, " wid"}, 32'(issue_wid), 32'(wid));
    chk({req, " pc"}, issue_pc, pc);
  endtask

  task automatic chk_idle(input string req);
    chk({req, " idle"}, 32'(issue_valid), 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_issue("R1 first issue after reset", 3'd0, 32'd0);
  endtask

  task automatic t_interleave();
    for (int k = 0; k < 8; k++) begin
      chk_issue("R10 R3 back-to-back issue", 3'(k), 32'd0);
      tick();
    end
    chk_idle("R4 all warps busy");
    tick();
    chk_idle("R2 busy warps not reissued");
  endtask

  task automatic t_writeback();
    wb_valid = 1'b1; wb_wid = 3'd3;
    tick();
    chk_issue("R5 sequential writeback", 3'd3, 32'd4);
    tick();
    chk_idle("R2 warp 3 back in flight");
  endtask

  task automatic t_branch();
    wb_valid = 1'b1; wb_wid = 3'd5; wb_is_branch = 1'b1; wb_target = 32'h100;
    tick();
    chk_issue("R6 branch target", 3'd5, 32'h100);
    tick();
  endtask

  task automatic t_miss_and_order();
    mem_result_valid = 1'b1; mem_result_wid = 3'd6; mem_all_hit = 1'b0;
    tick();
    chk_idle("R8 warp 6 parked");
    mem_return_valid = 1'b1; mem_return_wid = 3'd6;
    wb_valid = 1'b1; wb_wid = 3'd1;
    tick();
    chk_issue("R9 R3 woken warp 6 first after 5", 3'd6, 32'd4);
    tick();
    chk_issue("R3 warp 1 next", 3'd1, 32'd4);
    tick();
  endtask

  task automatic t_hit();
    mem_result_valid = 1'b1; mem_result_wid = 3'd4; mem_all_hit = 1'b1;
    tick();
    chk_idle("R7 hit keeps warp busy");
    wb_valid = 1'b1; wb_wid = 3'd4;
    tick();
    chk_issue("R7 issue after writeback", 3'd4, 32'd4);
    tick();
  endtask

  task automatic t_park_holds();
    mem_result_valid = 1'b1; mem_result_wid = 3'd2; mem_all_hit = 1'b0;
    tick();
    wb_valid = 1'b1; wb_wid = 3'd7;
    tick();
    chk_issue("R8 other warp issues, parked one skipped", 3'd7, 32'd4);
    tick();
    chk_idle("R8 parked warp 2 stays out");
    tick();
    chk_idle("R8 parked warp 2 still out");
    mem_return_valid = 1'b1; mem_return_wid = 3'd2;
    tick();
    chk_issue("R9 warp 2 after return", 3'd2, 32'd4);
    tick();
  endtask

  task automatic t_wrap();
    mem_result_valid = 1'b1; mem_result_wid = 3'd0; mem_all_hit = 1'b0;
    tick();
    mem_return_valid = 1'b1; mem_return_wid = 3'd0;
    wb_valid = 1'b1; wb_wid = 3'd7;
    tick();
    chk_issue("R3 warp 7 before wrap", 3'd7, 32'd8);
    tick();
    chk_issue("R3 wrap to warp 0", 3'd0, 32'd4);
    tick();
    chk_idle("R4 idle at end");
  endtask

  initial begin
    t_reset();
    t_interleave();
    t_writeback();
    t_branch();
    t_miss_and_order();
    t_hit();
    t_park_holds();
    t_wrap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule